// File: doc/BRIEF.md
# HDLC Frame Receiver with Station Address Filter

This block is the receive half of a bit-oriented synchronous link. It takes one serial line bit per strobe and, once enabled, hunts for the opening flag (`01111110`). The flag is recognised wherever it falls in the bit stream. Between flags it removes the zero that the sender inserted after every run of five ones. It packs the remaining bits into bytes, least significant bit first, and runs the CRC-CCITT check over them.

Output is a byte stream. The first byte of each frame, the station address, carries a start marker. Two received bytes are always held back. When the closing flag arrives, those two held bytes are the frame check sequence and are never delivered as data. The frame then ends with a separate end pulse that carries a CRC-error flag and an address-hit flag. The address hit is set when the address byte equals the programmed station address, is the broadcast value 0xFF, or is the test value 0x00 (the last only when `ACCEPT_TEST` is set). Control and information bytes pass through without interpretation. A single flag may close one frame and open the next.

Top module: `hdlc_rx_filter`

## Requirements
- R1: While `enable` is low, and after it rises until the first flag is seen, no byte and no end pulse is produced, whatever bits arrive.
- R2: The flag `01111110` is recognised at any bit position, with no alignment to earlier bits; a fragment shorter than three bytes between two flags is dropped without output.
- R3: A 0 that follows five consecutive 1 data bits is removed. It appears neither in the delivered bytes nor in the CRC computation.
- R4: The final 16 bits before the closing flag are treated as the frame check sequence and are never delivered. Delivery trails reception by two bytes.
- R5: At the closing flag `out_crc_err` is 0 only when the reflected CRC-CCITT register (polynomial 0x8408, start value 0xFFFF, covering every destuffed bit including the check sequence) ends at 0xF0B8 and the bit count is a whole number of bytes. Otherwise it is 1.
- R6: One flag may serve as the closing flag of one frame and the opening flag of the next. Both frames are delivered and each gets its own end pulse.
- R7: `out_addr_hit` in the end pulse is 1 when the first byte equals `station_addr`, equals 0xFF, or equals 0x00 with `ACCEPT_TEST`=1. It is 0 for any other value.
- R8: Seven consecutive 1s abort the frame. If bytes were already delivered, an end pulse with `out_crc_err`=1 follows. The receiver then ignores everything until the next flag.
- R9: A one-cycle `hunt_cmd` while a frame is open closes it in the same way as an abort (end pulse with `out_crc_err`=1 if bytes were delivered) and returns the receiver to hunting.
- R10: Bytes are assembled first-received bit into bit 0. `out_sof` is 1 only with the first delivered byte (the address). `out_eof` is a one-cycle pulse with `out_valid`=0.
- R11: A frame that holds fewer than three bytes between its flags produces no output at all.
- R12: Repeated flags with nothing between them produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low forces hunting |
| hunt_cmd | input | 1 | One-cycle request to abandon the frame and hunt |
| bit_valid | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| station_addr | input | 8 | Programmed station address |
| out_valid | output | 1 | A delivered byte is on `out_data` |
| out_data | output | 8 | Delivered byte |
| out_sof | output | 1 | The byte is the first of its frame |
| out_eof | output | 1 | End-of-frame pulse with status |
| out_crc_err | output | 1 | Status with `out_eof`: check failed or frame abandoned |
| out_addr_hit | output | 1 | Status with `out_eof`: address accepted |

## Verification
The embedded properties assume that `bit_valid` is never asserted in the same cycle as `hunt_cmd` or a falling `enable`. They also assume that `station_addr` is held steady for the whole of a frame. The directed stimulus drives each line bit on a falling edge, then leaves a one-cycle gap. It pulses `hunt_cmd` only in those gaps and changes `enable` and `station_addr` only between frames. This keeps every strobe, command and address change in separate cycles.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   localparam logic [15:0] CRC_INIT     = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_REV = 16'h8408;
   localparam logic [15:0] CRC_GOOD     = 16'hF0B8;

   // Classification of one line bit after flag and stuffing analysis
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_DATA  = 2'd1,
      EV_FLAG  = 2'd2,
      EV_ABORT = 2'd3
   } line_ev_e;

   // One step of the reflected CRC-CCITT shift register
   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[0] ^ b;
      return fb ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
   endfunction

endpackage

// File: rtl/hdlc_destuff.sv
module hdlc_destuff
   import hdlc_rx_pkg::*;
#(
   parameter int FLAG_ONES = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     bit_valid,
   input  logic     bit_in,
   output line_ev_e ev,
   output logic     dbit
);
   localparam int RUN_W = $clog2(FLAG_ONES + 2);
   localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(FLAG_ONES);
   localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(FLAG_ONES - 1);
   localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(FLAG_ONES + 1);

   initial begin
      if (FLAG_ONES < 2) $error("FLAG_ONES must be at least 2");
   end

   logic [RUN_W-1:0] ones_q;

   always_comb begin
      ev   = EV_NONE;
      dbit = bit_in;
      if (bit_valid) begin
         if (bit_in) ev = (ones_q == RUN_FLAG) ? EV_ABORT : EV_DATA;
         else if (ones_q == RUN_FLAG) ev = EV_FLAG;
         else if (ones_q == RUN_STUFF) ev = EV_NONE;
         else ev = EV_DATA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ones_q <= '0;
      else if (clr) ones_q <= '0;
      else if (bit_valid) begin
         if (!bit_in) ones_q <= '0;
         else if (ones_q != RUN_SAT) ones_q <= ones_q + 1'b1;
      end
   end

   assert_abort_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_ABORT && !clr) |=> ones_q == RUN_SAT);

   assert_flag_restarts_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_FLAG) |=> ones_q == '0);

endmodule

// File: rtl/hdlc_bit_delay.sv
module hdlc_bit_delay #(
   parameter int DEPTH = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);
   localparam int FILL_W = $clog2(DEPTH + 1);
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

   initial begin
      if (DEPTH < 1) $error("DEPTH must be at least 1");
   end

   logic [DEPTH-1:0]  pipe_q;
   logic [DEPTH-1:0]  pipe_nx;
   logic [FILL_W-1:0] fill_q;

   generate
      if (DEPTH == 1) begin : g_single
         assign pipe_nx = in_bit;
      end else begin : g_chain
         assign pipe_nx = {pipe_q[DEPTH-2:0], in_bit};
      end
   endgenerate

   assign out_valid = in_valid && !flush && (fill_q == FILL_MAX);
   assign out_bit   = pipe_q[DEPTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '0;
         fill_q <= '0;
      end else if (flush) begin
         fill_q <= '0;
      end else if (in_valid) begin
         pipe_q <= pipe_nx;
         if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
      end
   end

   assert_flush_holds_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

endmodule

// File: rtl/hdlc_framer.sv
module hdlc_framer
   import hdlc_rx_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int CRC_W       = 16,
   parameter int ACCEPT_TEST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hunt,
   input  logic              flag,
   input  logic              abort,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic [BYTE_W-1:0] station_addr,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_crc_err,
   output logic              out_addr_hit
);
   localparam int HOLD  = CRC_W / BYTE_W;
   localparam int CNT_W = $clog2(HOLD + 2);
   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD + 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

   initial begin
      if (CRC_W != 16) $error("CRC_W must be 16");
      if ((BYTE_W & (BYTE_W - 1)) != 0) $error("BYTE_W must be a power of two");
      if (CRC_W % BYTE_W != 0) $error("CRC_W must be a multiple of BYTE_W");
   end

   logic              in_frame;
   logic [BYTE_W-1:0] shreg;
   logic [BIT_W-1:0]  bitcnt;
   logic [CNT_W-1:0]  nbytes;
   logic [15:0]       crc_q;
   logic              addr_hit_q;
   logic [BYTE_W-1:0] hold_q [HOLD];

   logic [BYTE_W-1:0] new_byte;
   logic              byte_done;
   logic              test_hit;
   logic              addr_hit_now;
   logic              delivering;

   assign new_byte   = {bit_in, shreg[BYTE_W-1:1]};
   assign byte_done  = bit_valid && in_frame && (bitcnt == BIT_LAST);
   assign delivering = in_frame && (nbytes == CNT_FULL);

   generate
      if (ACCEPT_TEST != 0) begin : g_test_addr
         assign test_hit = (new_byte == '0);
      end else begin : g_no_test_addr
         assign test_hit = 1'b0;
      end
   endgenerate

   assign addr_hit_now = (new_byte == station_addr) || (&new_byte) || test_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame     <= 1'b0;
         shreg        <= '0;
         bitcnt       <= '0;
         nbytes       <= '0;
         crc_q        <= CRC_INIT;
         addr_hit_q   <= 1'b0;
         for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_sof      <= 1'b0;
         out_eof      <= 1'b0;
         out_crc_err  <= 1'b0;
         out_addr_hit <= 1'b0;
      end else begin
         out_valid    <= 1'b0;
         out_sof      <= 1'b0;
         out_eof      <= 1'b0;
         out_crc_err  <= 1'b0;
         out_addr_hit <= 1'b0;
         if (hunt || abort) begin
            if (delivering) begin
               out_eof      <= 1'b1;
               out_crc_err  <= 1'b1;
               out_addr_hit <= addr_hit_q;
            end
            in_frame <= 1'b0;
         end else if (flag) begin
            if (delivering) begin
               out_eof      <= 1'b1;
               out_crc_err  <= (crc_q != CRC_GOOD) || (bitcnt != '0);
               out_addr_hit <= addr_hit_q;
            end
            in_frame <= 1'b1;
            bitcnt   <= '0;
            nbytes   <= '0;
            crc_q    <= CRC_INIT;
         end else if (bit_valid && in_frame) begin
            crc_q  <= crc_step(crc_q, bit_in);
            bitcnt <= bitcnt + 1'b1;
            shreg  <= new_byte;
            if (byte_done) begin
               hold_q[0] <= new_byte;
               for (int i = 1; i < HOLD; i++) hold_q[i] <= hold_q[i-1];
               if (nbytes >= CNT_HOLD) begin
                  out_valid <= 1'b1;
                  out_data  <= hold_q[HOLD-1];
                  out_sof   <= (nbytes == CNT_HOLD);
               end
               if (nbytes != CNT_FULL) nbytes <= nbytes + 1'b1;
               if (nbytes == '0) addr_hit_q <= addr_hit_now;
            end
         end
      end
   end

   assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |=> !out_valid);

   assert_sof_with_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   assert_eof_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> !out_valid);

   assert_eof_after_delivery_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> $past(nbytes) == CNT_FULL);

   assert_status_only_at_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_crc_err || out_addr_hit) |-> out_eof);

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
   import hdlc_rx_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int CRC_W       = 16,
   parameter int FLAG_ONES   = 6,
   parameter int ACCEPT_TEST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              hunt_cmd,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic [BYTE_W-1:0] station_addr,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_crc_err,
   output logic              out_addr_hit
);
   // Bits of a flag that are taken as data before the flag is recognised
   localparam int LOOKAHEAD = FLAG_ONES + 1;

   initial begin
      if (BYTE_W != 8) $error("address field is fixed at 8 bits");
   end

   line_ev_e ev;
   logic     dbit;
   logic     hunt;
   logic     is_flag;
   logic     is_abort;
   logic     dl_valid;
   logic     dl_bit;

   assign hunt     = !enable || hunt_cmd;
   assign is_flag  = (ev == EV_FLAG);
   assign is_abort = (ev == EV_ABORT);

   hdlc_destuff #(.FLAG_ONES(FLAG_ONES)) u_destuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!enable),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .ev        (ev),
      .dbit      (dbit)
   );

   hdlc_bit_delay #(.DEPTH(LOOKAHEAD)) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (hunt || is_flag || is_abort),
      .in_valid  (ev == EV_DATA),
      .in_bit    (dbit),
      .out_valid (dl_valid),
      .out_bit   (dl_bit)
   );

   hdlc_framer #(
      .BYTE_W      (BYTE_W),
      .CRC_W       (CRC_W),
      .ACCEPT_TEST (ACCEPT_TEST)
   ) u_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .hunt         (hunt),
      .flag         (is_flag),
      .abort        (is_abort),
      .bit_valid    (dl_valid),
      .bit_in       (dl_bit),
      .station_addr (station_addr),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_sof      (out_sof),
      .out_eof      (out_eof),
      .out_crc_err  (out_crc_err),
      .out_addr_hit (out_addr_hit)
   );

endmodule

// File: tb/hdlc_rx_filter_bench.sv
module hdlc_rx_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] MY_ADDR = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       hunt_cmd = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic [7:0] station_addr = MY_ADDR;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_sof;
   logic       out_eof;
   logic       out_crc_err;
   logic       out_addr_hit;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] rec_data [0:63];
   logic       rec_sof  [0:63];
   int         rec_n = 0;
   logic       eof_err  [0:7];
   logic       eof_hit  [0:7];
   int         eof_n = 0;
   int         tx_ones = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_rx_filter u_hdlc_rx_filter (
      .clk (clk), .rst_n (rst_n), .enable (enable), .hunt_cmd (hunt_cmd),
      .bit_valid (bit_valid), .bit_in (bit_in), .station_addr (station_addr),
      .out_valid (out_valid), .out_data (out_data), .out_sof (out_sof),
      .out_eof (out_eof), .out_crc_err (out_crc_err), .out_addr_hit (out_addr_hit)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && rec_n < 64) begin
            rec_data[rec_n] = out_data;
            rec_sof[rec_n]  = out_sof;
            rec_n++;
         end
         if (out_eof && eof_n < 8) begin
            eof_err[eof_n] = out_crc_err;
            eof_hit[eof_n] = out_addr_hit;
            eof_n++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] fcs_of(input logic [7:0] fr [0:7], input int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++)
         for (int k = 0; k < 8; k++) begin
            logic fb = c[0] ^ fr[i][k];
            c = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      return ~c;
   endfunction

   task automatic raw_bit(input logic b);
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = b;
      @(negedge clk);
      bit_valid = 1'b0;
   endtask

   task automatic data_bit(input logic b);
      raw_bit(b);
      if (b) begin
         tx_ones++;
         if (tx_ones == 5) begin
            raw_bit(1'b0);
            tx_ones = 0;
         end
      end else tx_ones = 0;
   endtask

   task automatic data_byte(input logic [7:0] v);
      for (int k = 0; k < 8; k++) data_bit(v[k]);
   endtask

   task automatic raw_byte(input logic [7:0] v);
      for (int k = 0; k < 8; k++) raw_bit(v[k]);
   endtask

   task automatic send_flag();
      raw_byte(8'h7E);
      tx_ones = 0;
   endtask

   task automatic send_body(input logic [7:0] fr [0:7], input int n, input logic [15:0] corrupt);
      logic [15:0] f;
      f = fcs_of(fr, n) ^ corrupt;
      for (int i = 0; i < n; i++) data_byte(fr[i]);
      data_byte(f[7:0]);
      data_byte(f[15:8]);
   endtask

   task automatic clear_rec();
      repeat (4) @(negedge clk);
      rec_n = 0;
      eof_n = 0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic check_bytes(input string req, input logic [7:0] fr [0:7], input int n, input int base);
      for (int i = 0; i < n; i++) begin
         check(rec_data[base+i] == fr[i], req, "data byte", rec_data[base+i], fr[i]);
         check(rec_sof[base+i] == (i == 0), req, "sof marker", rec_sof[base+i], (i == 0));
      end
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0 && out_eof == 1'b0, "R10", "outputs idle after reset",
            {out_valid, out_eof}, 0);
   endtask

   task automatic t_basic();
      logic [7:0] fr [0:7] = '{8'h5A, 8'h03, 8'h11, 8'h22, 0, 0, 0, 0};
      clear_rec();
      raw_bit(1); raw_bit(0); raw_bit(1); raw_bit(1); raw_bit(0);   // hunting junk R1
      send_flag();
      send_body(fr, 4, 16'h0);
      send_flag();
      settle();
      check(rec_n == 4, "R4", "delivered count excludes FCS", rec_n, 4);
      check_bytes("R10", fr, 4, 0);
      check(eof_n == 1, "R10", "one end pulse", eof_n, 1);
      check(eof_err[0] == 1'b0, "R5", "good residue", eof_err[0], 0);
      check(eof_hit[0] == 1'b1, "R7", "own address hit", eof_hit[0], 1);
   endtask

   task automatic t_offset();
      logic [7:0] fr [0:7] = '{8'h5A, 8'hC3, 8'h99, 0, 0, 0, 0, 0};
      clear_rec();
      send_flag();
      raw_bit(1); raw_bit(1); raw_bit(0);      // three-bit fragment shifts the grid
      send_flag();
      send_body(fr, 3, 16'h0);
      send_flag();
      settle();
      check(rec_n == 3, "R2", "frame after odd offset delivered", rec_n, 3);
      check_bytes("R2", fr, 3, 0);
      check(eof_n == 1 && eof_err[0] == 1'b0, "R2", "fragment dropped, frame good",
            eof_n, 1);
   endtask

   task automatic t_stuff();
      logic [7:0] fr [0:7] = '{8'h5A, 8'hFF, 8'h7E, 8'hFC, 8'h3F, 8'hF8, 0, 0};
      clear_rec();
      send_flag();
      send_body(fr, 6, 16'h0);
      send_flag();
      settle();
      check(rec_n == 6, "R3", "stuffed frame length", rec_n, 6);
      check_bytes("R3", fr, 6, 0);
      check(eof_n == 1 && eof_err[0] == 1'b0, "R3", "stuffed zeros outside CRC",
            eof_err[0], 0);
   endtask

   task automatic t_back_to_back();
      logic [7:0] fa [0:7] = '{8'h5A, 8'h01, 8'hAA, 0, 0, 0, 0, 0};
      logic [7:0] fb [0:7] = '{8'hFF, 8'h02, 8'h55, 8'h66, 0, 0, 0, 0};
      clear_rec();
      send_flag();
      send_body(fa, 3, 16'h0);
      send_flag();                              // shared flag
      send_body(fb, 4, 16'h0);
      send_flag();
      settle();
      check(rec_n == 7, "R6", "both frames delivered", rec_n, 7);
      check_bytes("R6", fa, 3, 0);
      check_bytes("R6", fb, 4, 3);
      check(eof_n == 2, "R6", "two end pulses", eof_n, 2);
      check(eof_err[0] == 1'b0 && eof_err[1] == 1'b0, "R6", "both good",
            {eof_err[0], eof_err[1]}, 0);
      check(eof_hit[1] == 1'b1, "R7", "broadcast hit", eof_hit[1], 1);
   endtask

   task automatic t_bad_crc();
      logic [7:0] fr [0:7] = '{8'h5A, 8'h10, 8'h20, 0, 0, 0, 0, 0};
      clear_rec();
      send_flag();
      send_body(fr, 3, 16'h0100);
      send_flag();
      settle();
      check(eof_n == 1 && eof_err[0] == 1'b1, "R5", "corrupt FCS flagged", eof_err[0], 1);
      clear_rec();
      send_flag();
      send_body(fr, 3, 16'h0);
      raw_bit(0); raw_bit(0); raw_bit(0);       // not a whole byte
      send_flag();
      settle();
      check(eof_n == 1 && eof_err[0] == 1'b1, "R5", "misaligned frame flagged", eof_err[0], 1);
   endtask

   task automatic t_address();
      logic [7:0] f0 [0:7] = '{8'h00, 8'h01, 8'h02, 0, 0, 0, 0, 0};
      logic [7:0] f1 [0:7] = '{8'h37, 8'h01, 8'h02, 0, 0, 0, 0, 0};
      clear_rec();
      send_flag();
      send_body(f0, 3, 16'h0);
      send_flag();
      send_body(f1, 3, 16'h0);
      send_flag();
      settle();
      check(eof_n == 2, "R7", "two address frames", eof_n, 2);
      check(eof_hit[0] == 1'b1, "R7", "test address 0x00 hit", eof_hit[0], 1);
      check(eof_hit[1] == 1'b0, "R7", "foreign address miss", eof_hit[1], 0);
   endtask

   task automatic t_abort();
      logic [7:0] fr [0:7] = '{8'h5A, 8'h10, 8'h20, 8'h30, 8'h40, 0, 0, 0};
      logic [7:0] fg [0:7] = '{8'h5A, 8'h77, 8'h88, 0, 0, 0, 0, 0};
      int n_before;
      clear_rec();
      send_flag();
      for (int i = 0; i < 5; i++) data_byte(fr[i]);
      for (int i = 0; i < 7; i++) raw_bit(1'b1);
      settle();
      check(eof_n == 1 && eof_err[0] == 1'b1, "R8", "abort closes with error", eof_err[0], 1);
      check(rec_n >= 1 && rec_data[0] == 8'h5A && rec_sof[0], "R8", "partial delivery began",
            rec_data[0], 8'h5A);
      n_before = rec_n;
      raw_byte(8'h00); raw_byte(8'h00);
      settle();
      check(rec_n == n_before && eof_n == 1, "R8", "bits after abort ignored", rec_n, n_before);
      clear_rec();
      send_flag();
      send_body(fg, 3, 16'h0);
      send_flag();
      settle();
      check(rec_n == 3 && eof_n == 1 && eof_err[0] == 1'b0, "R8", "recovery after abort",
            rec_n, 3);
   endtask

   task automatic t_hunt_cmd();
      logic [7:0] fr [0:7] = '{8'h5A, 8'h10, 8'h20, 8'h30, 0, 0, 0, 0};
      clear_rec();
      send_flag();
      for (int i = 0; i < 4; i++) data_byte(fr[i]);
      @(negedge clk); hunt_cmd = 1'b1;
      @(negedge clk); hunt_cmd = 1'b0;
      raw_byte(8'h00); raw_byte(8'h00);
      settle();
      check(eof_n == 1 && eof_err[0] == 1'b1, "R9", "hunt command closes frame", eof_err[0], 1);
      check(rec_n == 1 && rec_data[0] == 8'h5A, "R9", "only address delivered before hunt",
            rec_n, 1);
   endtask

   task automatic t_short_and_idle();
      logic [7:0] fr [0:7] = '{8'h5A, 8'h01, 0, 0, 0, 0, 0, 0};
      clear_rec();
      send_flag(); send_flag(); send_flag();
      settle();
      check(rec_n == 0 && eof_n == 0, "R12", "repeated flags silent", rec_n + eof_n, 0);
      data_byte(fr[0]); data_byte(fr[1]);
      send_flag(); send_flag();
      settle();
      check(rec_n == 0 && eof_n == 0, "R11", "two-byte frame dropped", rec_n + eof_n, 0);
   endtask

   task automatic t_disabled();
      logic [7:0] fr [0:7] = '{8'h5A, 8'h44, 8'h45, 0, 0, 0, 0, 0};
      clear_rec();
      @(negedge clk); enable = 1'b0;
      send_flag();
      send_body(fr, 3, 16'h0);
      send_flag();
      settle();
      check(rec_n == 0 && eof_n == 0, "R1", "disabled receiver silent", rec_n + eof_n, 0);
      @(negedge clk); enable = 1'b1;
      send_body(fr, 3, 16'h0);                  // no opening flag yet: still hunting
      settle();
      check(rec_n == 0 && eof_n == 0, "R1", "hunting until first flag", rec_n + eof_n, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      enable = 1'b1;
      t_basic();
      t_offset();
      t_stuff();
      t_back_to_back();
      t_bad_crc();
      t_address();
      t_abort();
      t_hunt_cmd();
      t_short_and_idle();
      t_disabled();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule